// File: doc/BRIEF.md
# Multi-Source XOR Descriptor Executor

This block takes a single work descriptor and executes it against a simple word-addressed memory port. A descriptor is presented on input ports together with a one-cycle start pulse. The block captures it, checks it in one cycle, and then either moves data or ends the descriptor at once. The supported operations are no-op, memory copy, memory fill and XOR parity generation over one to eight source buffers into a single destination.

Data moves one 32-bit word at a time. For a copy or an XOR, every source word at the current offset is read in source-index order and folded into an accumulator, and then one destination word is written. Addresses are 48-bit byte addresses. The memory port carries their word part, bits [47:2]. The source list is packed: each pair of sources shares three 32-bit words. At the end, the block raises a one-cycle completion pulse, an optional interrupt pulse and an error flag.

Top module: `xor_desc_exec`

## Requirements
- R1: After reset, busy, done, irq, doneErr and memReq are all low, and the block waits for start.
- R2: The operation code is control bits [31:28]: 0 no-op, 1 copy, 2 fill, 6 XOR. Any other code completes with doneErr high and makes no memory access.
- R3: A valid no-op makes no memory access. Done is high, for exactly one cycle, in the second cycle after the start edge.
- R4: A copy reads source word address {descSrcHi[15:0], descSrcLo}[47:2]+i and writes the value read to {descDstHi[15:0], descDstLo}[47:2]+i. It takes three cycles per word: read, capture, write.
- R5: A fill writes the descSrcLo value to every destination word, one word per cycle, with no reads.
- R6: An XOR uses the source count in control bits [25:22]. Each destination word is the XOR of the words at the same offset in sources 0..n-1, read in index order, two cycles per source plus one write cycle.
- R7: In the source list, for each pair 2g and 2g+1, word 3g holds the low 32 bits of source 2g and word 3g+1 holds the low 32 bits of source 2g+1. Word 3g+2 holds address bits [47:32] of source 2g in [15:0] and of source 2g+1 in [31:16].
- R8: An XOR with a source count of 0 or above 8 completes with doneErr high and no memory access.
- R9: The byte count is rounded up to whole 4-byte words. A count of zero completes without error and makes no memory access.
- R10: irq pulses together with done exactly when control bit 27 of the descriptor was set.
- R11: While busy, start and any change on the descriptor inputs have no effect on the descriptor being executed.
- R12: An XOR needs the parity-enable bit (control bit 17) set and the second-parity bit (control bit 16) clear. Otherwise it completes with doneErr high and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture and launch the descriptor when idle |
| descCtrl | input | 32 | Control word: opcode, source count, flags |
| descBytes | input | 32 | Length in bytes |
| descSrcLo | input | 32 | Copy source address [31:0], or fill pattern |
| descSrcHi | input | 32 | Copy source address [47:32] in [15:0] |
| descDstLo | input | 32 | Destination address [31:0] |
| descDstHi | input | 32 | Destination address [47:32] in [15:0] |
| descSrcList | input | 384 | Packed source address list, 12 words |
| busy | output | 1 | A descriptor is in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt pulse, with done |
| doneErr | output | 1 | Descriptor rejected, valid with done |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | 46 | Word address |
| memWrData | output | 32 | Write data |
| memRdData | input | 32 | Read data, valid the cycle after a read |

## Verification
The bench builds the block with its defaults: eight sources, 48-bit addresses and a 32-bit byte count. This brings the full packed list within reach, including the odd member of the last pair and its upper half-word. It also reaches the count of 9, which the 4-bit count field can still carry, so the boundary on both sides of the legal range is exercised. Source addresses with distinct upper bits show any swap of the two 16-bit halves.

// File: rtl/xde_pkg.sv
package xde_pkg;
  localparam int DW      = 32;
  localparam int OPC_LSB = 28;
  localparam int OPC_W   = 4;
  localparam int CNT_LSB = 22;
  localparam int CNT_W   = 4;
  localparam int IRQ_BIT = 27;
  localparam int PEN_BIT = 17;
  localparam int QEN_BIT = 16;

  localparam logic [OPC_W-1:0] OP_NOP  = 4'd0;
  localparam logic [OPC_W-1:0] OP_COPY = 4'd1;
  localparam logic [OPC_W-1:0] OP_FILL = 4'd2;
  localparam logic [OPC_W-1:0] OP_XOR  = 4'd6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ, ST_CAPT, ST_WRITE, ST_DONE
  } xdeState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic rdIssue;
    logic capture;
    logic nextSrc;
    logic wrIssue;
    logic nextWord;
  } xdeStrobe_t;
endpackage

// File: rtl/xde_ctrl.sv
module xde_ctrl
  import xde_pkg::*;
#(
  parameter int MAX_SRC = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  input  logic [CNT_W-1:0] srcCnt,
  input  logic             pEn,
  input  logic             qEn,
  input  logic             irqReq,
  input  logic             noWords,
  input  logic             lastWord,
  input  logic             lastSrc,
  output xdeStrobe_t       strb,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic             err
);
  xdeState_e state, nxt;
  logic errQ;
  logic badDesc;
  logic cntOk;

  assign cntOk = (srcCnt != '0) && (int'(srcCnt) <= MAX_SRC);

  always_comb begin
    case (opcode)
      OP_NOP, OP_COPY, OP_FILL: badDesc = 1'b0;
      OP_XOR:                   badDesc = !(cntOk && pEn && !qEn);
      default:                  badDesc = 1'b1;
    endcase
  end

  always_comb begin
    strb = '0;
    nxt  = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          nxt = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (badDesc || opcode == OP_NOP || noWords) nxt = ST_DONE;
        else if (opcode == OP_FILL)                 nxt = ST_WRITE;
        else                                        nxt = ST_READ;
      end
      ST_READ: begin
        strb.rdIssue = 1'b1;
        nxt = ST_CAPT;
      end
      ST_CAPT: begin
        strb.capture = 1'b1;
        if (lastSrc) nxt = ST_WRITE;
        else begin
          strb.nextSrc = 1'b1;
          nxt = ST_READ;
        end
      end
      ST_WRITE: begin
        strb.wrIssue  = 1'b1;
        strb.nextWord = 1'b1;
        if (lastWord)                nxt = ST_DONE;
        else if (opcode == OP_FILL)  nxt = ST_WRITE;
        else                         nxt = ST_READ;
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= nxt;
      if (strb.load)                         errQ <= 1'b0;
      else if (state == ST_CHECK && badDesc) errQ <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
  assign irq  = done && irqReq;
  assign err  = done && errQ;

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> !strb.wrIssue);
  p_busy_after_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
endmodule

// File: rtl/xde_datapath.sv
module xde_datapath
  import xde_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int BYTE_W  = 32,
  parameter int MAX_SRC = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  xdeStrobe_t                             strb,
  input  logic [DW-1:0]                          descCtrl,
  input  logic [BYTE_W-1:0]                      descBytes,
  input  logic [DW-1:0]                          descSrcLo,
  input  logic [DW-1:0]                          descSrcHi,
  input  logic [DW-1:0]                          descDstLo,
  input  logic [DW-1:0]                          descDstHi,
  input  logic [3*((MAX_SRC+1)/2)*DW-1:0]        descSrcList,
  input  logic [DW-1:0]                          memRdData,
  output logic                                   memReq,
  output logic                                   memWe,
  output logic [ADDR_W-3:0]                      memAddr,
  output logic [DW-1:0]                          memWrData,
  output logic [OPC_W-1:0]                       opcode,
  output logic [CNT_W-1:0]                       srcCnt,
  output logic                                   pEn,
  output logic                                   qEn,
  output logic                                   irqReq,
  output logic                                   noWords,
  output logic                                   lastWord,
  output logic                                   lastSrc
);
  localparam int HI_W      = ADDR_W - DW;
  localparam int AW        = ADDR_W - 2;
  localparam int WORD_W    = BYTE_W - 1;
  localparam int SRC_IW    = (MAX_SRC > 1) ? $clog2(MAX_SRC) : 1;
  localparam int SRC_WORDS = 3 * ((MAX_SRC + 1) / 2);

  logic [DW-1:0]           ctrlQ;
  logic [WORD_W-1:0]       nWordsQ;
  logic [DW-1:0]           patQ;
  logic [ADDR_W-1:0]       cpSrcQ;
  logic [ADDR_W-1:0]       dstQ;
  logic [SRC_WORDS*DW-1:0] srcQ;
  logic [WORD_W-1:0]       wordIdx;
  logic [SRC_IW-1:0]       srcIdx;
  logic [DW-1:0]           acc;
  logic [WORD_W-1:0]       nWordsIn;

  assign nWordsIn = WORD_W'(descBytes >> 2) + WORD_W'(|descBytes[1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      nWordsQ <= '0;
      patQ    <= '0;
      cpSrcQ  <= '0;
      dstQ    <= '0;
      srcQ    <= '0;
      wordIdx <= '0;
      srcIdx  <= '0;
      acc     <= '0;
    end else begin
      if (strb.load) begin
        ctrlQ   <= descCtrl;
        nWordsQ <= nWordsIn;
        patQ    <= descSrcLo;
        cpSrcQ  <= {descSrcHi[HI_W-1:0], descSrcLo};
        dstQ    <= {descDstHi[HI_W-1:0], descDstLo};
        srcQ    <= descSrcList;
        wordIdx <= '0;
        srcIdx  <= '0;
      end
      if (strb.capture) acc <= (srcIdx == '0) ? memRdData : (acc ^ memRdData);
      if (strb.nextSrc) srcIdx <= srcIdx + SRC_IW'(1);
      if (strb.nextWord) begin
        wordIdx <= wordIdx + WORD_W'(1);
        srcIdx  <= '0;
      end
    end
  end

  // unpack the source list: a pair shares two low words and one high word
  logic [AW-1:0] srcWord [MAX_SRC];
  for (genvar k = 0; k < MAX_SRC; k++) begin : g_srcAddr
    localparam int GB = 3 * (k / 2);
    if (k % 2 == 0) begin : g_even
      assign srcWord[k] = {srcQ[(GB+2)*DW +: HI_W], srcQ[GB*DW+2 +: DW-2]};
    end else begin : g_odd
      assign srcWord[k] = {srcQ[(GB+2)*DW+HI_W +: HI_W], srcQ[(GB+1)*DW+2 +: DW-2]};
    end
  end

  assign opcode  = ctrlQ[OPC_LSB +: OPC_W];
  assign srcCnt  = ctrlQ[CNT_LSB +: CNT_W];
  assign pEn     = ctrlQ[PEN_BIT];
  assign qEn     = ctrlQ[QEN_BIT];
  assign irqReq  = ctrlQ[IRQ_BIT];
  assign noWords = (nWordsQ == '0);
  assign lastWord = (wordIdx == nWordsQ - WORD_W'(1));
  assign lastSrc  = (opcode != OP_XOR) || (CNT_W'(srcIdx) + CNT_W'(1) == srcCnt);

  logic [AW-1:0] rdBase;
  assign rdBase = (opcode == OP_XOR) ? srcWord[srcIdx] : cpSrcQ[ADDR_W-1:2];

  assign memReq    = strb.rdIssue || strb.wrIssue;
  assign memWe     = strb.wrIssue;
  assign memAddr   = (strb.rdIssue ? rdBase : dstQ[ADDR_W-1:2]) + AW'(wordIdx);
  assign memWrData = (opcode == OP_FILL) ? patQ : acc;

  logic unusedBits;
  assign unusedBits = ^{srcQ, ctrlQ, cpSrcQ[1:0], dstQ[1:0], descSrcHi, descDstHi};

  p_src_in_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdIssue && opcode == OP_XOR) |-> (CNT_W'(srcIdx) < srcCnt));
  p_wr_in_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrIssue |-> (wordIdx < nWordsQ));
endmodule

// File: rtl/xor_desc_exec.sv
module xor_desc_exec
  import xde_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int BYTE_W  = 32,
  parameter int MAX_SRC = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            start,
  input  logic [31:0]                     descCtrl,
  input  logic [BYTE_W-1:0]               descBytes,
  input  logic [31:0]                     descSrcLo,
  input  logic [31:0]                     descSrcHi,
  input  logic [31:0]                     descDstLo,
  input  logic [31:0]                     descDstHi,
  input  logic [3*((MAX_SRC+1)/2)*32-1:0] descSrcList,
  output logic                            busy,
  output logic                            done,
  output logic                            irq,
  output logic                            doneErr,
  output logic                            memReq,
  output logic                            memWe,
  output logic [ADDR_W-3:0]               memAddr,
  output logic [31:0]                     memWrData,
  input  logic [31:0]                     memRdData
);
  xdeStrobe_t       strb;
  logic [OPC_W-1:0] opcode;
  logic [CNT_W-1:0] srcCnt;
  logic pEn, qEn, irqReq, noWords, lastWord, lastSrc;

  xde_ctrl #(.MAX_SRC(MAX_SRC)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .opcode(opcode), .srcCnt(srcCnt), .pEn(pEn), .qEn(qEn), .irqReq(irqReq),
    .noWords(noWords), .lastWord(lastWord), .lastSrc(lastSrc),
    .strb(strb), .busy(busy), .done(done), .irq(irq), .err(doneErr)
  );

  xde_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .MAX_SRC(MAX_SRC)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .descCtrl(descCtrl), .descBytes(descBytes),
    .descSrcLo(descSrcLo), .descSrcHi(descSrcHi),
    .descDstLo(descDstLo), .descDstHi(descDstHi),
    .descSrcList(descSrcList), .memRdData(memRdData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .opcode(opcode), .srcCnt(srcCnt), .pEn(pEn), .qEn(qEn), .irqReq(irqReq),
    .noWords(noWords), .lastWord(lastWord), .lastSrc(lastSrc)
  );
endmodule

// File: tb/xor_desc_exec_tb_top.sv
module xor_desc_exec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] descCtrl = '0, descBytes = '0;
  logic [31:0] descSrcLo = '0, descSrcHi = '0, descDstLo = '0, descDstHi = '0;
  logic [383:0] descSrcList = '0;
  logic busy, done, irq, doneErr, memReq, memWe;
  logic [45:0] memAddr;
  logic [31:0] memWrData;
  logic [31:0] memRdData = '0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xor_desc_exec dut_i (
    .clk(clk), .rstN(rstN), .start(start), .descCtrl(descCtrl), .descBytes(descBytes),
    .descSrcLo(descSrcLo), .descSrcHi(descSrcHi), .descDstLo(descDstLo), .descDstHi(descDstHi),
    .descSrcList(descSrcList), .busy(busy), .done(done), .irq(irq), .doneErr(doneErr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData)
  );

  // behavioural memory with one-cycle read latency
  logic [31:0] mem [longint];

  function automatic logic [31:0] rdWord(longint a);
    if (mem.exists(a)) return mem[a];
    return 32'(a * 64'h9E3779B1) ^ 32'h5A5A_0F0F;
  endfunction

  always @(posedge clk) begin
    if (memReq && memWe) mem[longint'(memAddr)] = memWrData;
    if (memReq && !memWe) memRdData <= rdWord(longint'(memAddr));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual cycles=%0d expected below 100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  typedef struct {
    bit req; bit we; longint addr; logic [31:0] wd;
    bit busyE; bit doneE; bit irqE; bit errE;
  } expRec_t;

  function automatic logic [31:0] mkCtrl(int opc, int cnt, bit irqB, bit pB, bit qB);
    logic [31:0] c;
    c = '0;
    c[31:28] = opc[3:0];
    c[25:22] = cnt[3:0];
    c[27] = irqB;
    c[17] = pB;
    c[16] = qB;
    return c;
  endfunction

  task automatic checkCycle(string tag, expRec_t e);
    bit bad;
    bad = (memReq !== e.req) || (memWe !== e.we) || (busy !== e.busyE) ||
          (done !== e.doneE) || (irq !== (e.doneE && e.irqE)) ||
          (e.doneE && doneErr !== e.errE) ||
          (e.req && memAddr !== e.addr[45:0]) || (e.we && memWrData !== e.wd);
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: actual req=%0b we=%0b addr=%h wd=%h busy=%0b done=%0b irq=%0b err=%0b expected req=%0b we=%0b addr=%h wd=%h busy=%0b done=%0b irq=%0b err=%0b",
               tag, memReq, memWe, memAddr, memWrData, busy, done, irq, doneErr,
               e.req, e.we, e.addr[45:0], e.wd, e.busyE, e.doneE, e.irqE, e.errE);
    end
  endtask

  function automatic expRec_t mkRec(bit req, bit we, longint addr, logic [31:0] wd);
    expRec_t r;
    r.req = req; r.we = we; r.addr = addr; r.wd = wd;
    r.busyE = 1'b1; r.doneE = 1'b0; r.irqE = 1'b0; r.errE = 1'b0;
    return r;
  endfunction

  task automatic runDesc(string tag, logic [31:0] ctrl, logic [31:0] bytes, longint srcA,
                         longint dstA, logic [31:0] pat, longint srcs[8], bit holdStart);
    expRec_t q[$];
    expRec_t fin;
    expRec_t idle;
    int opc, cnt;
    bit bad;
    longint nW, srcW, dstW;
    logic [383:0] pk;
    logic [31:0] v;
    opc = int'(ctrl[31:28]);
    cnt = int'(ctrl[25:22]);
    case (opc)
      0, 1, 2: bad = 0;
      6:       bad = (cnt == 0) || (cnt > 8) || !ctrl[17] || ctrl[16];
      default: bad = 1;
    endcase
    nW   = (longint'(bytes) + 3) / 4;
    srcW = srcA >> 2;
    dstW = dstA >> 2;
    pk = '0;
    for (int k = 0; k < 8; k++) begin
      int g;
      g = k / 2;
      if (k % 2 == 0) begin
        pk[(3*g)*32 +: 32]   = srcs[k][31:0];
        pk[(3*g+2)*32 +: 16] = srcs[k][47:32];
      end else begin
        pk[(3*g+1)*32 +: 32]    = srcs[k][31:0];
        pk[(3*g+2)*32+16 +: 16] = srcs[k][47:32];
      end
    end
    q.push_back(mkRec(0, 0, 0, '0));
    if (!bad && opc != 0) begin
      for (longint i = 0; i < nW; i++) begin
        if (opc == 2) q.push_back(mkRec(1, 1, dstW + i, pat));
        else if (opc == 1) begin
          q.push_back(mkRec(1, 0, srcW + i, '0));
          q.push_back(mkRec(0, 0, 0, '0));
          q.push_back(mkRec(1, 1, dstW + i, rdWord(srcW + i)));
        end else begin
          v = '0;
          for (int k = 0; k < cnt; k++) begin
            q.push_back(mkRec(1, 0, (srcs[k] >> 2) + i, '0));
            q.push_back(mkRec(0, 0, 0, '0));
            v ^= rdWord((srcs[k] >> 2) + i);
          end
          q.push_back(mkRec(1, 1, dstW + i, v));
        end
      end
    end
    fin = mkRec(0, 0, 0, '0);
    fin.doneE = 1'b1; fin.irqE = ctrl[27]; fin.errE = bad;
    q.push_back(fin);

    @(negedge clk);
    descCtrl    = ctrl;
    descBytes   = bytes;
    descSrcLo   = (opc == 2) ? pat : srcA[31:0];
    descSrcHi   = {16'hBEEF, srcA[47:32]};
    descDstLo   = dstA[31:0];
    descDstHi   = {16'hF00D, dstA[47:32]};
    descSrcList = pk;
    start       = 1'b1;
    @(negedge clk);
    if (holdStart) begin
      // new descriptor on the pins while busy must be ignored (R11)
      descCtrl  = mkCtrl(2, 0, 1, 0, 0);
      descBytes = 32'd64;
      descSrcLo = 32'hDEAD_BEEF;
      descDstLo = 32'h0000_4000;
    end else start = 1'b0;
    foreach (q[idx]) begin
      if (idx == q.size() - 1) start = 1'b0;
      checkCycle(tag, q[idx]);
      @(negedge clk);
    end
    idle = mkRec(0, 0, 0, '0);
    idle.busyE = 1'b0;
    checkCycle(tag, idle);
  endtask

  initial begin
    longint s8[8];
    longint z8[8];
    expRec_t rst;
    z8 = '{default: 64'h0};
    s8 = '{64'h0000_1111_0000_2000, 64'h0000_2222_0000_3000, 64'h0000_3333_0000_5000,
           64'h0000_4444_0000_6000, 64'h0000_5555_0000_7000, 64'h0000_6666_0000_8000,
           64'h0000_7777_0000_9000, 64'h0000_8888_0000_A000};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    rst = mkRec(0, 0, 0, '0);
    rst.busyE = 1'b0;
    checkCycle("R1", rst);

    runDesc("R3", mkCtrl(0, 0, 1, 0, 0), 32'd64, 64'h100, 64'h200, '0, z8, 0);
    runDesc("R10", mkCtrl(0, 0, 0, 0, 0), 32'd8, 64'h100, 64'h200, '0, z8, 0);
    runDesc("R4", mkCtrl(1, 0, 0, 0, 0), 32'd12, 64'h0000_AB12_0000_1000,
            64'h0000_0034_0000_8000, '0, z8, 0);
    runDesc("R9", mkCtrl(1, 0, 1, 0, 0), 32'd5, 64'h0000_0001_0000_0040,
            64'h0000_0002_0000_0080, '0, z8, 0);
    runDesc("R9", mkCtrl(1, 0, 0, 0, 0), 32'd0, 64'h0000_0001_0000_0040,
            64'h0000_0002_0000_0080, '0, z8, 0);
    runDesc("R5", mkCtrl(2, 0, 1, 0, 0), 32'd16, 64'h0, 64'h0000_0055_0000_0100,
            32'hC0FF_EE11, z8, 0);
    runDesc("R6", mkCtrl(6, 1, 0, 1, 0), 32'd8, 64'h0, 64'h0000_0099_0000_0000,
            '0, s8, 0);
    runDesc("R6", mkCtrl(6, 3, 1, 1, 0), 32'd8, 64'h0, 64'h0000_0099_0000_1000,
            '0, s8, 0);
    runDesc("R7", mkCtrl(6, 8, 0, 1, 0), 32'd4, 64'h0, 64'h0000_0099_0000_2000,
            '0, s8, 0);
    runDesc("R8", mkCtrl(6, 0, 1, 1, 0), 32'd8, 64'h0, 64'h0000_0099_0000_3000,
            '0, s8, 0);
    runDesc("R8", mkCtrl(6, 9, 0, 1, 0), 32'd8, 64'h0, 64'h0000_0099_0000_3000,
            '0, s8, 0);
    runDesc("R2", mkCtrl(3, 0, 0, 0, 0), 32'd8, 64'h100, 64'h200, '0, z8, 0);
    runDesc("R2", mkCtrl(5, 0, 1, 0, 0), 32'd8, 64'h100, 64'h200, '0, z8, 0);
    runDesc("R2", mkCtrl(7, 2, 0, 1, 1), 32'd8, 64'h0, 64'h200, '0, s8, 0);
    runDesc("R2", mkCtrl(15, 0, 0, 0, 0), 32'd8, 64'h100, 64'h200, '0, z8, 0);
    runDesc("R12", mkCtrl(6, 2, 0, 0, 0), 32'd8, 64'h0, 64'h0000_0099_0000_4000,
            '0, s8, 0);
    runDesc("R12", mkCtrl(6, 2, 1, 1, 1), 32'd8, 64'h0, 64'h0000_0099_0000_4000,
            '0, s8, 0);
    runDesc("R11", mkCtrl(1, 0, 0, 0, 0), 32'd8, 64'h0000_0777_0000_0400,
            64'h0000_0123_0000_0800, '0, z8, 1);
    runDesc("R4", mkCtrl(1, 0, 0, 0, 0), 32'd4, 64'h0000_0123_0000_0800,
            64'h0000_0124_0000_0800, '0, z8, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule